// File: doc/BRIEF.md
# NAND Flash Device Command Front End

This block is the device-side front end of an asynchronous 8-bit NAND flash bus. The host writes bytes with chip enable low. A byte is an opcode when the command latch is high, an address byte when the address latch is high, and program data when both latches are low. The block decodes opcodes and collects address bytes. It decides when a read, program or erase starts and hands that operation to a separate array engine. Read ID bytes and the status byte are produced locally.

Array operations are one-cycle request pulses. Each pulse carries the operation kind, the row and the column. The front end then counts as busy until the engine returns a done pulse with a fail flag. Read data is streamed from the engine's byte port, indexed by the front end's column pointer. Program data bytes are forwarded one at a time, each tagged with its column. Page geometry and the number of address bytes are set by parameters: a small-page device uses 512+16 byte pages, and a large-page device uses 2048+64 byte pages.

Top module: `nand_cmd_frontend`

## Requirements
- R1: A bus write is ignored entirely while `ce_n` is high. With `ce_n` low, `cle` high makes the byte an opcode. `ale` high makes it an address byte, placed into byte slot N of a 5-byte address register, where N is the number of address bytes taken since the last count reset (least significant slot first). Bytes beyond the fifth are dropped.
- R2: Opcode 0x90 followed by one address byte arms the ID response. The next reads return `MANUF_ID`, `DEVICE_ID`, 0xA5, and then a geometry byte: 0x15 for a large-page device, 0xC0 for a small-page device. Later reads return 0x00.
- R3: Under opcode 0x00, a read request starts on the address byte that brings the count to 3 (small page), 4 (large page, `BIG_DEVICE`=0) or 5 (large page, `BIG_DEVICE`=1). Its row is the address above the column bytes. Its column is the column bytes (1 byte on small page, 2 on large) plus a pending offset. Opcode 0x01 sets that offset to 0x100 and opcode 0x50 sets it to the page size. Both then behave as 0x00.
- R4: After the read completes, each data read returns `arr_rdata` for the current `rd_col` and then advances `rd_col`. Once (page + spare − start column) bytes have been read, reads return 0x00. Opcode 0x00, issued while loaded read data is present, resumes streaming where it stopped.
- R5: After opcode 0x70, every read returns the status byte and leaves `rd_col` unchanged.
- R6: Status byte = {`wp_n`, ready, 5'b0, error}. Ready is low from a request until `arr_done`. Error is `arr_fail` captured at `arr_done`.
- R7: Under 0x80 or 0x85, once the address bytes are complete, each data byte pulses `data_we` with `data_col` starting at the address column and incrementing. Opcode 0x10 requests a program of that row and column only if `wp_n` is high.
- R8: Opcode 0x60 with its address bytes, followed by 0xD0, requests an erase only if `wp_n` is high. The row of that erase is the address bytes received, with every slot at or above the byte count forced to zero.
- R9: Opcode 0xFF returns the current command to 0x00 and clears the address, the byte count, the offset, the output stream and the error bit. It sets ready; bit 7 still follows `wp_n`.
- R10: Every opcode resets the address-byte count except 0xE0. On a large-page device, 0x05 clears the column bits and the count, and 0xE0 then requests a read at the new column of the same row.
- R11: On a large-page device, 0x30 received while the current command is 0x00 is ignored completely: streaming continues.
- R12: A read with `ce_n` high returns 0x00 and advances nothing. A read when no output is armed also returns 0x00.
- R13: `req_valid` is a single-cycle pulse, with at most one request outstanding. An operation that would start while one is outstanding is dropped.
- R14: An unknown opcode becomes the current command, stops any output (reads give 0x00), and starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Byte is an opcode |
| ale | input | 1 | Byte is an address byte |
| wp_n | input | 1 | Write protect, active low |
| wr_stb | input | 1 | Bus write strobe, one cycle per byte |
| din | input | 8 | Bus write byte |
| rd_stb | input | 1 | Bus read strobe, one cycle per byte |
| dout | output | 8 | Read byte, valid the cycle after `rd_stb` |
| req_valid | output | 1 | Array request pulse |
| req_op | output | 2 | 0 read, 1 program, 2 erase |
| req_row | output | ROW_BITS | Request row |
| req_col | output | 16 | Request column |
| arr_done | input | 1 | Array operation finished |
| arr_fail | input | 1 | Operation failed, valid with `arr_done` |
| rd_col | output | 16 | Column of the byte to be streamed next |
| arr_rdata | input | 8 | Array byte at `rd_col` |
| data_we | output | 1 | Program data byte valid |
| data_byte | output | 8 | Program data byte |
| data_col | output | 16 | Column of `data_byte` |

## Verification
The bound checker watches, on every cycle, the rules that span a few cycles at the ports. These are: request pulses are one cycle long and never overlap an outstanding operation; program or erase requests only follow a write taken while `wp_n` was high; reads with chip enable high give zero; and data pulses only follow plain data writes. Which opcode sequences lead to which request, with which row and column, can only be shown by the bench scenarios. The same holds for the ID byte order, the end of the output stream, the resume and ignore behaviour of 0x00 and 0x30, masking of erase rows, and what reset clears. The bench checks these against a request queue and the bytes it expects.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

    localparam logic [7:0] OPC_READ       = 8'h00;
    localparam logic [7:0] OPC_READ_HI    = 8'h01;
    localparam logic [7:0] OPC_READ_SPARE = 8'h50;
    localparam logic [7:0] OPC_READ_GO    = 8'h30;
    localparam logic [7:0] OPC_RAND_SETUP = 8'h05;
    localparam logic [7:0] OPC_RAND_GO    = 8'hE0;
    localparam logic [7:0] OPC_IDENT      = 8'h90;
    localparam logic [7:0] OPC_RESET      = 8'hFF;
    localparam logic [7:0] OPC_PROG       = 8'h80;
    localparam logic [7:0] OPC_PROG_GO    = 8'h10;
    localparam logic [7:0] OPC_ERASE      = 8'h60;
    localparam logic [7:0] OPC_ERASE_GO   = 8'hD0;
    localparam logic [7:0] OPC_STATUS     = 8'h70;
    localparam logic [7:0] OPC_COPY_IN    = 8'h85;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } arr_op_e;

    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_IDENT  = 2'd1,
        OUT_STATUS = 2'd2,
        OUT_ARRAY  = 2'd3
    } out_mode_e;

    typedef enum logic [3:0] {
        K_READ, K_READ_HI, K_READ_SPARE, K_IGNORE, K_RAND_SETUP, K_RAND_GO,
        K_IDENT, K_RESET, K_PROG, K_PROG_GO, K_ERASE, K_ERASE_GO, K_STATUS,
        K_COPY_IN, K_OTHER
    } cmd_kind_e;

endpackage

// File: rtl/nand_fe_opdecode.sv
module nand_fe_opdecode
    import nand_fe_pkg::*;
#(
    parameter bit LARGE_PAGE = 1'b1
) (
    input  logic [7:0] opcode,
    input  logic [7:0] cur_cmd,
    output cmd_kind_e  kind
);

    always_comb begin
        case (opcode)
            OPC_READ:       kind = K_READ;
            OPC_READ_HI:    kind = K_READ_HI;
            OPC_READ_SPARE: kind = K_READ_SPARE;
            OPC_READ_GO:    kind = (LARGE_PAGE && cur_cmd == OPC_READ) ? K_IGNORE : K_OTHER;
            OPC_RAND_SETUP: kind = LARGE_PAGE ? K_RAND_SETUP : K_OTHER;
            OPC_RAND_GO:    kind = K_RAND_GO;
            OPC_IDENT:      kind = K_IDENT;
            OPC_RESET:      kind = K_RESET;
            OPC_PROG:       kind = K_PROG;
            OPC_PROG_GO:    kind = K_PROG_GO;
            OPC_ERASE:      kind = K_ERASE;
            OPC_ERASE_GO:   kind = K_ERASE_GO;
            OPC_STATUS:     kind = K_STATUS;
            OPC_COPY_IN:    kind = K_COPY_IN;
            default:        kind = K_OTHER;
        endcase
    end

endmodule

// File: rtl/nand_fe_idresp.sv
module nand_fe_idresp #(
    parameter bit         LARGE_PAGE = 1'b1,
    parameter logic [7:0] MANUF_ID   = 8'h3E,
    parameter logic [7:0] DEVICE_ID  = 8'h7B,
    parameter logic [7:0] FILLER_ID  = 8'hA5
) (
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);

    logic [7:0] geom_byte;

    generate
        if (LARGE_PAGE) begin : g_large
            assign geom_byte = 8'h15;
        end else begin : g_small
            assign geom_byte = 8'hC0;
        end
    endgenerate

    always_comb begin
        case (idx)
            3'd0:    id_byte = MANUF_ID;
            3'd1:    id_byte = DEVICE_ID;
            3'd2:    id_byte = FILLER_ID;
            3'd3:    id_byte = geom_byte;
            default: id_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/nand_fe_trigger.sv
module nand_fe_trigger #(
    parameter bit LARGE_PAGE = 1'b1,
    parameter bit BIG_DEVICE = 1'b1
) (
    input  logic [2:0] cnt_now,
    input  logic [2:0] cnt_next,
    output logic       fire,
    output logic       armed
);

    localparam int CYCLES = !LARGE_PAGE ? 3 : (BIG_DEVICE ? 5 : 4);

    assign fire  = (cnt_next == 3'(CYCLES)) && (cnt_now != cnt_next);
    assign armed = (cnt_now >= 3'(CYCLES));

endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
    import nand_fe_pkg::*;
#(
    parameter bit         LARGE_PAGE = 1'b1,
    parameter bit         BIG_DEVICE = 1'b1,
    parameter logic [7:0] MANUF_ID   = 8'h3E,
    parameter logic [7:0] DEVICE_ID  = 8'h7B,
    parameter int         ROW_BITS   = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                cle,
    input  logic                ale,
    input  logic                wp_n,
    input  logic                wr_stb,
    input  logic [7:0]          din,
    input  logic                rd_stb,
    output logic [7:0]          dout,
    output logic                req_valid,
    output logic [1:0]          req_op,
    output logic [ROW_BITS-1:0] req_row,
    output logic [15:0]         req_col,
    input  logic                arr_done,
    input  logic                arr_fail,
    output logic [15:0]         rd_col,
    input  logic [7:0]          arr_rdata,
    output logic                data_we,
    output logic [7:0]          data_byte,
    output logic [15:0]         data_col
);

    localparam int ADDR_BYTES = 5;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int PAGE_BYTES = LARGE_PAGE ? 2048 : 512;
    localparam int SPARE      = PAGE_BYTES / 32;
    localparam int SPAN       = PAGE_BYTES + SPARE;
    localparam int COL_W      = LARGE_PAGE ? 16 : 8;

    typedef struct packed {
        logic [7:0]          cmd;
        logic [ADDR_W-1:0]   addr;
        logic [2:0]          acnt;
        logic [15:0]         offset;
        out_mode_e           mode;
        logic [2:0]          idx;
        logic [15:0]         col;
        logic [15:0]         rem;
        logic                busy;
        arr_op_e             op;
        logic                err;
        logic                loaded;
        logic                req_valid;
        arr_op_e             req_op;
        logic [ROW_BITS-1:0] req_row;
        logic [15:0]         req_col;
        logic [7:0]          dout;
        logic                data_we;
        logic [7:0]          data_byte;
        logic [15:0]         data_col;
    } state_t;

    state_t q, d;

    cmd_kind_e  kind;
    logic [2:0] cnt_next;
    logic       fire, armed;
    logic [7:0] id_byte;

    nand_fe_opdecode #(.LARGE_PAGE(LARGE_PAGE)) u_dec (
        .opcode  (din),
        .cur_cmd (q.cmd),
        .kind    (kind)
    );

    assign cnt_next = (int'(q.acnt) < ADDR_BYTES) ? q.acnt + 3'd1 : q.acnt;

    nand_fe_trigger #(.LARGE_PAGE(LARGE_PAGE), .BIG_DEVICE(BIG_DEVICE)) u_trig (
        .cnt_now  (q.acnt),
        .cnt_next (cnt_next),
        .fire     (fire),
        .armed    (armed)
    );

    nand_fe_idresp #(
        .LARGE_PAGE (LARGE_PAGE),
        .MANUF_ID   (MANUF_ID),
        .DEVICE_ID  (DEVICE_ID),
        .FILLER_ID  (8'hA5)
    ) u_id (
        .idx     (q.idx),
        .id_byte (id_byte)
    );

    logic                go;
    arr_op_e             go_op;
    logic [ROW_BITS-1:0] go_row;
    logic [15:0]         go_col;
    logic [ADDR_W-1:0]   addr_n;
    logic [ADDR_W-1:0]   masked;
    logic [7:0]          status;

    assign status = {wp_n, ~q.busy, 5'b0, q.err};

    always_comb begin
        d      = q;
        go     = 1'b0;
        go_op  = OP_READ;
        go_row = '0;
        go_col = '0;
        addr_n = q.addr;
        masked = q.addr;
        d.req_valid = 1'b0;
        d.data_we   = 1'b0;

        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (i >= int'(q.acnt)) masked[i*8 +: 8] = 8'h00;
        end

        // completion from the array engine
        if (arr_done && q.busy) begin
            d.busy = 1'b0;
            d.err  = arr_fail;
            if (q.op == OP_READ) begin
                d.loaded = 1'b1;
                d.rem    = (q.col < 16'(SPAN)) ? 16'(SPAN) - q.col : 16'd0;
                if (q.mode == OUT_NONE) d.mode = OUT_ARRAY;
            end
        end

        // bus write
        if (wr_stb && !ce_n) begin
            if (cle) begin
                case (kind)
                    K_IGNORE: ;
                    K_RAND_SETUP: begin
                        d.addr[COL_W-1:0] = '0;
                        d.acnt = '0;
                    end
                    default: begin
                        d.cmd  = din;
                        d.mode = OUT_NONE;
                        if (kind != K_RAND_GO) d.acnt = '0;
                        case (kind)
                            K_READ: begin
                                d.offset = '0;
                                if (q.loaded) d.mode = OUT_ARRAY;
                            end
                            K_READ_HI: begin
                                d.cmd    = OPC_READ;
                                d.offset = 16'h0100;
                            end
                            K_READ_SPARE: begin
                                d.cmd    = OPC_READ;
                                d.offset = 16'(PAGE_BYTES);
                            end
                            K_STATUS: d.mode = OUT_STATUS;
                            K_PROG, K_COPY_IN: d.loaded = 1'b0;
                            K_PROG_GO: begin
                                go     = wp_n;
                                go_op  = OP_PROG;
                                go_row = ROW_BITS'(q.addr >> COL_W);
                                go_col = 16'(q.addr[COL_W-1:0]);
                            end
                            K_ERASE_GO: begin
                                go     = wp_n;
                                go_op  = OP_ERASE;
                                go_row = ROW_BITS'(masked);
                            end
                            K_RAND_GO: begin
                                go     = LARGE_PAGE;
                                go_op  = OP_READ;
                                go_row = ROW_BITS'(q.addr >> COL_W);
                                go_col = 16'(q.addr[COL_W-1:0]);
                            end
                            K_RESET: d = '0;
                            default: ;
                        endcase
                    end
                endcase
            end else if (ale) begin
                if (int'(q.acnt) < ADDR_BYTES) addr_n[int'(q.acnt)*8 +: 8] = din;
                d.addr = addr_n;
                d.acnt = cnt_next;
                if (q.cmd == OPC_IDENT && cnt_next == 3'd1 && q.acnt == 3'd0) begin
                    d.mode = OUT_IDENT;
                    d.idx  = '0;
                end
                if (fire && q.cmd == OPC_READ) begin
                    go       = 1'b1;
                    go_op    = OP_READ;
                    go_row   = ROW_BITS'(addr_n >> COL_W);
                    go_col   = 16'(addr_n[COL_W-1:0]) + q.offset;
                    d.offset = '0;
                end
                if (fire && (q.cmd == OPC_PROG || q.cmd == OPC_COPY_IN)) begin
                    d.col = 16'(addr_n[COL_W-1:0]);
                end
            end else if (armed && (q.cmd == OPC_PROG || q.cmd == OPC_COPY_IN)
                         && q.col < 16'(SPAN)) begin
                d.data_we   = 1'b1;
                d.data_byte = din;
                d.data_col  = q.col;
                d.col       = q.col + 16'd1;
            end
        end

        // launch one array operation at a time
        if (go && !d.busy) begin
            d.req_valid = 1'b1;
            d.req_op    = go_op;
            d.req_row   = go_row;
            d.req_col   = go_col;
            d.busy      = 1'b1;
            d.op        = go_op;
            d.loaded    = 1'b0;
            if (go_op == OP_READ) begin
                d.mode = OUT_NONE;
                d.col  = go_col;
            end
        end

        // bus read
        if (rd_stb) begin
            d.dout = 8'h00;
            if (!ce_n) begin
                case (q.mode)
                    OUT_IDENT: begin
                        if (q.idx < 3'd4) begin
                            d.dout = id_byte;
                            d.idx  = q.idx + 3'd1;
                        end
                    end
                    OUT_STATUS: d.dout = status;
                    OUT_ARRAY: begin
                        if (q.rem != 16'd0) begin
                            d.dout = arr_rdata;
                            d.col  = q.col + 16'd1;
                            d.rem  = q.rem - 16'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout      = q.dout;
    assign req_valid = q.req_valid;
    assign req_op    = q.req_op;
    assign req_row   = q.req_row;
    assign req_col   = q.req_col;
    assign rd_col    = q.col;
    assign data_we   = q.data_we;
    assign data_byte = q.data_byte;
    assign data_col  = q.data_col;

endmodule

// File: rtl/nand_fe_checker.sv
module nand_fe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       cle,
    input logic       ale,
    input logic       wp_n,
    input logic       wr_stb,
    input logic [7:0] din,
    input logic       rd_stb,
    input logic [7:0] dout,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       arr_done,
    input logic       data_we
);

    logic outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
        end else if (req_valid) begin
            outstanding <= 1'b1;
        end else if (arr_done || (wr_stb && !ce_n && cle && din == 8'hFF)) begin
            outstanding <= 1'b0;
        end
    end

    assert_req_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    assert_single_outstanding_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !outstanding);

    assert_protect_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'd0) |-> $past(wp_n));

    assert_ce_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stb && ce_n) |-> dout == 8'h00);

    assert_data_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |-> $past(wr_stb && !ce_n && !cle && !ale));

endmodule

bind nand_cmd_frontend nand_fe_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .cle       (cle),
    .ale       (ale),
    .wp_n      (wp_n),
    .wr_stb    (wr_stb),
    .din       (din),
    .rd_stb    (rd_stb),
    .dout      (dout),
    .req_valid (req_valid),
    .req_op    (req_op),
    .arr_done  (arr_done),
    .data_we   (data_we)
);

// File: tb/nand_cmd_frontend_test.sv
`timescale 1ns/1ps
module nand_cmd_frontend_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b0, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
    logic        wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [7:0]  dout;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [23:0] req_row;
    logic [15:0] req_col;
    logic        arr_done = 1'b0, arr_fail = 1'b0;
    logic [15:0] rd_col;
    logic [7:0]  arr_rdata;
    logic        data_we;
    logic [7:0]  data_byte;
    logic [15:0] data_col;

    int n_chk = 0;
    int n_fail = 0;
    int eng_cnt = 0;
    int eng_delay = 3;
    bit eng_fail = 1'b0;
    int exp_op[$];
    int exp_row[$];
    int exp_col[$];
    logic [7:0] v;

    always #5 clk = ~clk;

    nand_cmd_frontend uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
        .wr_stb(wr_stb), .din(din), .rd_stb(rd_stb), .dout(dout),
        .req_valid(req_valid), .req_op(req_op), .req_row(req_row), .req_col(req_col),
        .arr_done(arr_done), .arr_fail(arr_fail), .rd_col(rd_col), .arr_rdata(arr_rdata),
        .data_we(data_we), .data_byte(data_byte), .data_col(data_col)
    );

    function automatic logic [7:0] pat(input int col);
        return 8'(col) ^ 8'h5A;
    endfunction

    assign arr_rdata = pat(int'(rd_col));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural array engine and request comparison, every clock
    always @(negedge clk) begin
        arr_done = 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                arr_done = 1'b1;
                arr_fail = eng_fail;
            end
        end
        if (rst_n && req_valid) begin
            if (exp_op.size() == 0) begin
                chk("R13 unexpected request", 1, 0);
            end else begin
                chk("R3 request op", int'(req_op), exp_op.pop_front());
                chk("R3 request row", int'(req_row), exp_row.pop_front());
                chk("R3 request col", int'(req_col), exp_col.pop_front());
            end
            eng_cnt = eng_delay;
        end
    end

    task automatic expect_req(input int op, input int row, input int col);
        exp_op.push_back(op);
        exp_row.push_back(row);
        exp_col.push_back(col);
    endtask

    task automatic bw(input bit c, input bit a, input logic [7:0] b, input bit ce = 1'b0);
        @(negedge clk);
        ce_n = ce; cle = c; ale = a; din = b; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        bw(1'b1, 1'b0, b);
    endtask

    task automatic adr(input logic [7:0] b);
        bw(1'b0, 1'b1, b);
    endtask

    task automatic br(output logic [7:0] r, input bit ce = 1'b0);
        @(negedge clk);
        ce_n = ce; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; ce_n = 1'b0;
        r = dout;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // reset state
        chk("R9 reset dout", int'(dout), 0);
        chk("R13 reset req_valid", int'(req_valid), 0);
        chk("R7 reset data_we", int'(data_we), 0);
        chk("R9 reset rd_col", int'(rd_col), 0);
        br(v); chk("R12 read with no output armed", int'(v), 0);
        cmd(8'h70); br(v); chk("R9 reset status", int'(v), 'hC0);

        // R2 ID bytes, with R1 and R12 chip-enable cases
        cmd(8'h90); adr(8'h00);
        br(v); chk("R2 id byte 0", int'(v), 'h3E);
        bw(1'b1, 1'b0, 8'h70, 1'b1);
        br(v); chk("R1 ignored write under ce_n high", int'(v), 'h7B);
        br(v, 1'b1); chk("R12 read under ce_n high", int'(v), 0);
        br(v); chk("R12 no advance on ce_n high", int'(v), 'hA5);
        br(v); chk("R2 geometry byte", int'(v), 'h15);
        br(v); chk("R2 after last id byte", int'(v), 0);

        // R5 status with write protect asserted
        wp_n = 1'b0;
        cmd(8'h70);
        br(v); chk("R5 status wp low", int'(v), 'h40);
        br(v); chk("R5 status repeats", int'(v), 'h40);
        chk("R5 rd_col held", int'(rd_col), 0);
        wp_n = 1'b1;

        // R3 read after five address bytes, R11 0x30 ignored
        cmd(8'h00);
        adr(8'h34); adr(8'h01); adr(8'h05); adr(8'h00);
        expect_req(0, 'h05, 'h134);
        adr(8'h00);
        cmd(8'h30);
        idle(8);
        chk("R3 request consumed", exp_op.size(), 0);
        for (int i = 0; i < 3; i++) begin
            br(v); chk("R4 stream byte", int'(v), int'(pat('h134 + i)));
        end
        chk("R4 rd_col advanced", int'(rd_col), 'h137);
        cmd(8'h70); br(v); chk("R6 status ready", int'(v), 'hC0);
        cmd(8'h00);
        br(v); chk("R4 resume after 0x00", int'(v), int'(pat('h137)));
        cmd(8'h30);
        br(v); chk("R11 0x30 ignored, stream continues", int'(v), int'(pat('h138)));

        // R10 random data output, R4 end of stream
        cmd(8'h05); adr(8'h30);
        expect_req(0, 'h05, 'h830);
        adr(8'h08); cmd(8'hE0);
        idle(8);
        chk("R10 request consumed", exp_op.size(), 0);
        for (int i = 0; i < 16; i++) begin
            br(v); chk("R4 tail byte", int'(v), int'(pat('h830 + i)));
        end
        br(v); chk("R4 past end of page", int'(v), 0);

        // R7 program, data forwarding and protect gate
        cmd(8'h80);
        adr(8'h10); adr(8'h00); adr(8'h03); adr(8'h00); adr(8'h00);
        bw(1'b0, 1'b0, 8'hAA);
        chk("R7 data_we first", int'(data_we), 1);
        chk("R7 data byte first", int'(data_byte), 'hAA);
        chk("R7 data col first", int'(data_col), 'h10);
        bw(1'b0, 1'b0, 8'hBB);
        chk("R7 data byte second", int'(data_byte), 'hBB);
        chk("R7 data col second", int'(data_col), 'h11);
        expect_req(1, 'h03, 'h10);
        cmd(8'h10);
        idle(8);
        chk("R7 program request consumed", exp_op.size(), 0);
        wp_n = 1'b0;
        cmd(8'h80);
        adr(8'h00); adr(8'h00); adr(8'h04); adr(8'h00); adr(8'h00);
        cmd(8'h10);
        idle(8);

        // R8 erase with row masking, protected erase
        wp_n = 1'b1;
        cmd(8'h60); adr(8'h01);
        expect_req(2, 'h01, 0);
        cmd(8'hD0);
        idle(8);
        chk("R8 erase request consumed", exp_op.size(), 0);
        wp_n = 1'b0;
        cmd(8'h60); adr(8'h09); cmd(8'hD0);
        idle(8);
        wp_n = 1'b1;

        // R13 second operation while busy is dropped
        eng_delay = 20;
        cmd(8'h60); adr(8'h07); adr(8'h02); adr(8'h00);
        expect_req(2, 'h0207, 0);
        cmd(8'hD0);
        cmd(8'h60); adr(8'h02); cmd(8'hD0);
        idle(30);
        chk("R13 only first request seen", exp_op.size(), 0);

        // R6 busy and error bits
        eng_delay = 6;
        eng_fail = 1'b1;
        expect_req(2, 'h04, 0);
        cmd(8'h60); adr(8'h04); cmd(8'hD0);
        cmd(8'h70);
        br(v); chk("R6 ready low while busy", int'(v), 'h80);
        idle(10);
        br(v); chk("R6 error after failed op", int'(v), 'hC1);

        // R9 reset clears stream and error
        eng_delay = 3;
        cmd(8'h00);
        adr(8'h00); adr(8'h00); adr(8'h06); adr(8'h00);
        expect_req(0, 'h06, 0);
        adr(8'h00);
        idle(8);
        br(v); chk("R4 stream before reset", int'(v), int'(pat(0)));
        cmd(8'hFF);
        cmd(8'h00);
        br(v); chk("R9 stream cleared by reset", int'(v), 0);
        cmd(8'h70);
        br(v); chk("R9 error cleared, ready set", int'(v), 'hC0);
        wp_n = 1'b0;
        br(v); chk("R9 bit 7 follows wp_n", int'(v), 'h40);
        wp_n = 1'b1;
        eng_fail = 1'b0;

        // R14 unknown opcode
        cmd(8'h90); adr(8'h00);
        cmd(8'h3C);
        br(v); chk("R14 unknown opcode stops output", int'(v), 0);
        adr(8'h00); adr(8'h00); adr(8'h01); adr(8'h00); adr(8'h00);
        idle(8);
        chk("R14 no request from unknown opcode", exp_op.size(), 0);

        report();
    end

endmodule